// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit serves the memory-reference instructions of a 32-bit load-store processor that has 32 general registers. It takes one instruction word and the already-advanced program counter. It decodes the word and, when the address needs a base register, asks the register file for exactly one read. It then produces the effective address. It also produces a memory command (read, write or none) and the register index that the instruction names. For the two address-load forms it produces a value to write straight back into a register instead of touching memory. Words that are not memory-reference instructions come back with a rejection flag and no side effects.

The control is a four-state machine. `IDLE` waits for a word and holds `in_ready` high. The *accept-based* transition goes to `REQ` when the base field is nonzero on an absolute-capable opcode. The *accept-direct* transition goes to `RESOLVE` otherwise. `REQ` drives the register read and always takes the *request-issued* transition to `WAIT`. In `WAIT` the read data arrives, and the *base-consumed* transition forms the result and returns to `IDLE`. In `RESOLVE` the *direct-formed* transition forms the result without a read and returns to `IDLE`. Results are registered and stay held until the next result is formed. `done` marks the first cycle in which a new result is valid.

Top module: `eau_top`

## Requirements
- R1: The opcode is bits 31:27 of the word. `mem_cmd` is encoded as 0 = none, 1 = read, 2 = write. Opcodes 1 and 2 give read, opcodes 3 and 4 give write, and opcodes 5 and 6 give none.
- R2: For opcodes 1, 3 and 5 with the base field (bits 21:17) equal to zero, the address is bits 21:0 sign-extended from bit 21. No register read is issued.
- R3: For opcodes 1, 3 and 5 with a nonzero base field, exactly one register read of that index is issued. The address is the returned value plus bits 16:0 sign-extended from bit 16, taken modulo 2^32.
- R4: Opcodes 2, 4 and 6 form `pc_next` plus bits 21:0 sign-extended from bit 21. Bits 21:17 never cause a register read.
- R5: Opcodes 5 and 6 raise `wb_en`, give `wb_value` equal to the formed address and give a memory command of none. Opcode 6 with a zero constant yields `pc_next` itself.
- R6: For opcodes 1 to 6, `reg_idx` equals bits 26:22. For opcodes 1 to 4, `wb_en` is low.
- R7: Any other opcode sets `not_mine` and gives a memory command of none, `wb_en` low, `eff_addr` and `reg_idx` zero, and no register read.
- R8: Count the accepting clock edge as edge 0. `reg_rd_en` is high only between edges 0 and 1, and only when a base read is needed. `reg_rd_data` is sampled at edge 2. `done` is high after edge 1 without a read and after edge 2 with one.
- R9: `in_ready` is high only in the idle state. `instr_valid` is ignored while `in_ready` is low.
- R10: After reset, `in_ready` is 1, and `done`, `reg_rd_en`, `mem_cmd`, `wb_en` and `not_mine` are 0.
- R11: `done` lasts one cycle, and every result output keeps its value until the next result is formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Instruction word |
| pc_next | input | 32 | Address of the following instruction |
| in_ready | output | 1 | Unit idle, word accepted this cycle if valid |
| reg_rd_en | output | 1 | Register read request |
| reg_rd_idx | output | 5 | Register index to read |
| reg_rd_data | input | 32 | Register value, valid one cycle after the request |
| done | output | 1 | New result valid this cycle |
| not_mine | output | 1 | Word is not a memory-reference instruction |
| mem_cmd | output | 2 | 0 none, 1 read, 2 write |
| eff_addr | output | 32 | Effective address |
| reg_idx | output | 5 | Destination (load) or source (store) register |
| wb_en | output | 1 | Address is to be written back to a register |
| wb_value | output | 32 | Value for register write-back |

## Verification
On every cycle the assertions check the following. A register read never lasts two cycles, and it never names index zero. `in_ready` is low whenever a read is pending. A rejected word never carries a memory command or a write-back. An address-load never carries a memory command. `done` is never high on two cycles in a row. Only the bench's scenarios can show the actual arithmetic. These include sign extension of both constant widths, wrap-around of a negative displacement, the relative forms ignoring their base bits, the exact latency of each path and the rejection of a second word offered while busy.

// File: rtl/eau_pkg.sv
`timescale 1ns/1ps
package eau_pkg;

    localparam int OPC_W = 5;

    localparam logic [OPC_W-1:0] OPC_LD   = 5'd1;
    localparam logic [OPC_W-1:0] OPC_LDR  = 5'd2;
    localparam logic [OPC_W-1:0] OPC_ST   = 5'd3;
    localparam logic [OPC_W-1:0] OPC_STR  = 5'd4;
    localparam logic [OPC_W-1:0] OPC_LA   = 5'd5;
    localparam logic [OPC_W-1:0] OPC_LAR  = 5'd6;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } mem_cmd_e;

    typedef enum logic [1:0] {
        BASE_ZERO = 2'd0,
        BASE_REG  = 2'd1,
        BASE_PC   = 2'd2
    } base_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQ     = 2'd1,
        ST_WAIT    = 2'd2,
        ST_RESOLVE = 2'd3
    } eau_state_e;

    typedef struct packed {
        logic     known;
        mem_cmd_e cmd;
        logic     rel;
        logic     wb;
        logic     based;
    } dec_t;

endpackage

// File: rtl/eau_decode.sv
`timescale 1ns/1ps
module eau_decode
    import eau_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5,
    parameter int C1_W   = 22,
    parameter int C2_W   = 17
) (
    input  logic [XLEN-1:0]   word,
    output dec_t              dec,
    output logic [RIDX_W-1:0] ra,
    output logic [RIDX_W-1:0] rb,
    output logic [XLEN-1:0]   disp
);

    localparam int OP_LSB = XLEN - OPC_W;
    localparam int RA_LSB = OP_LSB - RIDX_W;

    logic [OPC_W-1:0] op;
    logic [XLEN-1:0]  c1_ext;
    logic [XLEN-1:0]  c2_ext;
    logic             rb_zero;

    assign op      = word[XLEN-1 -: OPC_W];
    assign ra      = word[OP_LSB-1 -: RIDX_W];
    assign rb      = word[RA_LSB-1 -: RIDX_W];
    assign rb_zero = (rb == '0);
    assign c1_ext  = {{(XLEN-C1_W){word[C1_W-1]}}, word[C1_W-1:0]};
    assign c2_ext  = {{(XLEN-C2_W){word[C2_W-1]}}, word[C2_W-1:0]};

    always_comb begin
        dec       = '0;
        dec.cmd   = CMD_NONE;
        unique case (op)
            OPC_LD, OPC_ST, OPC_LA: begin
                dec.known = 1'b1;
                dec.based = !rb_zero;
            end
            OPC_LDR, OPC_STR, OPC_LAR: begin
                dec.known = 1'b1;
                dec.rel   = 1'b1;
            end
            default: dec.known = 1'b0;
        endcase
        unique case (op)
            OPC_LD, OPC_LDR: dec.cmd = CMD_READ;
            OPC_ST, OPC_STR: dec.cmd = CMD_WRITE;
            OPC_LA, OPC_LAR: dec.wb  = 1'b1;
            default:         dec.cmd = CMD_NONE;
        endcase
        disp = dec.based ? c2_ext : c1_ext;
    end

endmodule

// File: rtl/eau_agen.sv
`timescale 1ns/1ps
module eau_agen
    import eau_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  base_sel_e       sel,
    input  logic [XLEN-1:0] reg_base,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] disp,
    output logic [XLEN-1:0] addr
);

    logic [XLEN-1:0] base;

    always_comb begin
        unique case (sel)
            BASE_REG: base = reg_base;
            BASE_PC:  base = pc;
            default:  base = '0;
        endcase
    end

    assign addr = base + disp;

endmodule

// File: rtl/eau_top.sv
`timescale 1ns/1ps
module eau_top
    import eau_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5,
    parameter int C1_W   = 22,
    parameter int C2_W   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [XLEN-1:0]   instr_word,
    input  logic [XLEN-1:0]   pc_next,
    output logic              in_ready,
    output logic              reg_rd_en,
    output logic [RIDX_W-1:0] reg_rd_idx,
    input  logic [XLEN-1:0]   reg_rd_data,
    output logic              done,
    output logic              not_mine,
    output logic [1:0]        mem_cmd,
    output logic [XLEN-1:0]   eff_addr,
    output logic [RIDX_W-1:0] reg_idx,
    output logic              wb_en,
    output logic [XLEN-1:0]   wb_value
);

    eau_state_e        state_q, state_d;
    logic [XLEN-1:0]   word_q, pc_q;
    logic [XLEN-1:0]   dec_word, dec_pc;
    dec_t              dec;
    logic [RIDX_W-1:0] ra, rb;
    logic [XLEN-1:0]   disp, addr;
    base_sel_e         sel;
    logic              forming;

    logic              done_q, not_mine_q, wb_en_q;
    mem_cmd_e          cmd_q;
    logic [XLEN-1:0]   addr_q, wb_val_q;
    logic [RIDX_W-1:0] idx_q;

    assign dec_word = (state_q == ST_IDLE) ? instr_word : word_q;
    assign dec_pc   = (state_q == ST_IDLE) ? pc_next    : pc_q;

    eau_decode #(
        .XLEN(XLEN), .RIDX_W(RIDX_W), .C1_W(C1_W), .C2_W(C2_W)
    ) u_decode (
        .word(dec_word), .dec(dec), .ra(ra), .rb(rb), .disp(disp)
    );

    always_comb begin
        if (dec.rel)        sel = BASE_PC;
        else if (dec.based) sel = BASE_REG;
        else                sel = BASE_ZERO;
    end

    eau_agen #(.XLEN(XLEN)) u_agen (
        .sel(sel), .reg_base(reg_rd_data), .pc(dec_pc), .disp(disp), .addr(addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (instr_valid) state_d = dec.based ? ST_REQ : ST_RESOLVE;
            ST_REQ:     state_d = ST_WAIT;
            ST_WAIT:    state_d = ST_IDLE;
            ST_RESOLVE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && instr_valid) begin
                word_q <= instr_word;
                pc_q   <= pc_next;
            end
        end
    end

    assign forming = (state_q == ST_WAIT) || (state_q == ST_RESOLVE);

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            not_mine_q <= 1'b0;
            wb_en_q    <= 1'b0;
            cmd_q      <= CMD_NONE;
            addr_q     <= '0;
            wb_val_q   <= '0;
            idx_q      <= '0;
        end else begin
            done_q <= forming;
            if (forming) begin
                not_mine_q <= !dec.known;
                wb_en_q    <= dec.known && dec.wb;
                cmd_q      <= dec.known ? dec.cmd : CMD_NONE;
                addr_q     <= dec.known ? addr : '0;
                wb_val_q   <= (dec.known && dec.wb) ? addr : '0;
                idx_q      <= dec.known ? ra : '0;
            end
        end
    end

    assign in_ready   = (state_q == ST_IDLE);
    assign reg_rd_en  = (state_q == ST_REQ);
    assign reg_rd_idx = (state_q == ST_REQ) ? rb : '0;
    assign done       = done_q;
    assign not_mine   = not_mine_q;
    assign wb_en      = wb_en_q;
    assign mem_cmd    = cmd_q;
    assign eff_addr   = addr_q;
    assign wb_value   = wb_val_q;
    assign reg_idx    = idx_q;

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);  // R3
    AST_READ_HAS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> reg_rd_idx != '0);  // R3
    AST_BUSY_WHILE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> !in_ready);  // R9
    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && not_mine) |-> (mem_cmd == CMD_NONE && !wb_en));  // R7
    AST_WB_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wb_en) |-> mem_cmd == CMD_NONE);  // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R11

endmodule

// File: tb/eau_top_tb.sv
`timescale 1ns/1ps
module eau_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] pc_next = '0;
    logic        in_ready, reg_rd_en, done, not_mine, wb_en;
    logic [4:0]  reg_rd_idx, reg_idx;
    logic [31:0] reg_rd_data = '0;
    logic [1:0]  mem_cmd;
    logic [31:0] eff_addr, wb_value;

    int checks = 0;
    int errors = 0;
    logic [31:0] regs [32];

    always #2 clk = ~clk;

    eau_top u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .pc_next(pc_next), .in_ready(in_ready), .reg_rd_en(reg_rd_en),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data), .done(done),
        .not_mine(not_mine), .mem_cmd(mem_cmd), .eff_addr(eff_addr),
        .reg_idx(reg_idx), .wb_en(wb_en), .wb_value(wb_value)
    );

    // register file model: data one cycle after the request
    always @(posedge clk) if (reg_rd_en) reg_rd_data <= regs[reg_rd_idx];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_c1(input logic [4:0] op, input logic [4:0] ra,
                                           input logic [21:0] c);
        return {op, ra, c};
    endfunction

    function automatic logic [31:0] enc_c2(input logic [4:0] op, input logic [4:0] ra,
                                           input logic [4:0] rb, input logic [16:0] c);
        return {op, ra, rb, c};
    endfunction

    task automatic run(input logic [31:0] w, input logic [31:0] pc, input bit hold);
        logic [4:0]  op = w[31:27];
        logic [4:0]  ra = w[26:22];
        logic [4:0]  rb = w[21:17];
        logic [31:0] c1x = {{10{w[21]}}, w[21:0]};
        logic [31:0] c2x = {{15{w[16]}}, w[16:0]};
        logic [31:0] e_addr = '0;
        logic [1:0]  e_cmd = 2'd0;
        bit          based = 0, known = 1, e_wb = 0;
        string       tag;
        int          dk;
        case (op)
            5'd1, 5'd3, 5'd5: begin
                if (rb == 0) begin e_addr = c1x; tag = "R2"; end
                else begin based = 1; e_addr = regs[rb] + c2x; tag = "R3"; end
            end
            5'd2, 5'd4, 5'd6: begin e_addr = pc + c1x; tag = "R4"; end
            default: begin known = 0; tag = "R7"; end
        endcase
        if (op == 5'd1 || op == 5'd2) e_cmd = 2'd1;
        if (op == 5'd3 || op == 5'd4) e_cmd = 2'd2;
        if (op == 5'd5 || op == 5'd6) begin e_wb = 1; tag = "R5"; end
        dk = based ? 2 : 1;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        pc_next     = pc;
        for (int k = 1; k <= dk + 2; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (hold) begin
                    instr_word = enc_c1(5'd1, 5'd2, 22'h00033);
                    pc_next    = 32'hDEAD_0000;
                end else instr_valid = 1'b0;
            end
            if (k == 2) instr_valid = 1'b0;
            check(reg_rd_en == (k == 1 && based), "R8", "reg_rd_en timing",
                  {31'd0, reg_rd_en}, {31'd0, (k == 1 && based)});
            if (k == 1 && based)
                check(reg_rd_idx == rb, "R3", "read index", {27'd0, reg_rd_idx}, {27'd0, rb});
            check(in_ready == (k > dk), "R9", "in_ready", {31'd0, in_ready}, {31'd0, (k > dk)});
            check(done == (k == dk + 1), "R8", "done timing", {31'd0, done}, {31'd0, (k == dk + 1)});
            if (k >= dk + 1) begin
                string ht = (k == dk + 1) ? tag : "R11";
                check(eff_addr == (known ? e_addr : 32'd0), ht, "eff_addr", eff_addr,
                      known ? e_addr : 32'd0);
                check(mem_cmd == e_cmd, (k == dk + 1) ? "R1" : "R11", "mem_cmd",
                      {30'd0, mem_cmd}, {30'd0, e_cmd});
                check(not_mine == !known, "R7", "not_mine", {31'd0, not_mine}, {31'd0, !known});
                check(reg_idx == (known ? ra : 5'd0), "R6", "reg_idx",
                      {27'd0, reg_idx}, {27'd0, (known ? ra : 5'd0)});
                check(wb_en == e_wb, "R6", "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
                check(wb_value == (e_wb ? e_addr : 32'd0), "R5", "wb_value", wb_value,
                      e_wb ? e_addr : 32'd0);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 32'h1000_0000 + i * 32'h111;
        regs[7] = 32'h0000_0004;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R10", "reset in_ready", {31'd0, in_ready}, 32'd1);
        check(done == 1'b0 && reg_rd_en == 1'b0, "R10", "reset done/read",
              {30'd0, done, reg_rd_en}, 32'd0);
        check(mem_cmd == 2'd0 && !wb_en && !not_mine, "R10", "reset outputs",
              {28'd0, mem_cmd, wb_en, not_mine}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run(enc_c1(5'd1, 5'd3, 22'h00ABCD), 32'h0000_5000, 0);          // R2 absolute load
        run(enc_c2(5'd1, 5'd22, 5'd4, 17'd24), 32'h0000_5004, 0);       // R3 displacement
        run(enc_c2(5'd1, 5'd8, 5'd7, 17'h1FFF8), 32'h0000_5008, 0);     // R3 wrap below zero
        run(enc_c1(5'd2, 5'd12, 22'h3FFFD0), 32'h0000_6000, 0);         // R4 pc - 48
        run(enc_c1(5'd2, 5'd1, 22'h2A1234), 32'h0001_0000, 0);          // R4 base bits ignored
        run(enc_c2(5'd3, 5'd9, 5'd2, 17'd0), 32'h0000_6004, 0);         // R1 store, R6 source
        run(enc_c1(5'd4, 5'd17, 22'd100), 32'h0000_7000, 0);            // R4 store-relative
        run(enc_c1(5'd5, 5'd7, 22'd32), 32'h0000_7004, 0);              // R5 load-address
        run(enc_c2(5'd5, 5'd30, 5'd5, 17'h1FFFF), 32'h0000_7008, 0);    // R5 based minus one
        run(enc_c1(5'd6, 5'd3, 22'd0), 32'h0000_8000, 0);               // R5 yields pc
        run(enc_c1(5'd6, 5'd31, 22'h1FFFFF), 32'hFFF0_0000, 0);         // R4 max positive
        run(enc_c2(5'd0, 5'd4, 5'd6, 17'd5), 32'h0000_9000, 0);         // R7 opcode 0
        run(enc_c2(5'd7, 5'd4, 5'd6, 17'd5), 32'h0000_9004, 0);         // R7 opcode 7
        run(enc_c1(5'd31, 5'd9, 22'h3FFFFF), 32'h0000_9008, 0);         // R7 opcode 31
        run(enc_c2(5'd1, 5'd10, 5'd11, 17'd64), 32'h0000_A000, 1);      // R9 busy hold, based
        run(enc_c1(5'd5, 5'd2, 22'd9), 32'h0000_A004, 1);               // R9 busy hold, direct

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule